// File: doc/BRIEF.md
# Decimation Phase and Sync Controller

This block sequences the conversion cycles of an oversampling converter and decides which conversion refreshes the decimated (filtered) output. A rising edge on the master-clock request starts a conversion. The controller raises a busy indication and emits a one-cycle start pulse to the converter core, then waits for the core's done flag. A phase counter counts completed conversions modulo the active down-sampling factor (DF). Every DF-th conversion is a boundary conversion: the data-ready-low line goes high when it starts and falls when it finishes, and in that same cycle a one-cycle load enable tells the filtered output register to capture the new word.

A two-bit strap selects the down-sampling factor. The strap is latched only at reset and at a synchronization pulse, so toggling the pins during operation does not move the phase. A synchronization pulse is edge-detected. If the phase counter already sits at zero and the strap matches the active factor, the pulse changes nothing. Otherwise the counter is forced to zero, the new factor is latched, and a one-cycle clear is sent to the filter accumulator. A pulse that arrives during a conversion is held and applied in the first idle cycle after that conversion completes.

All control and status pins are plain levels or pulses. The block carries no data stream, so there is no handshake and no back-pressure.

Top module: `decim_phase_ctrl`

## Requirements
- R1: The strap value s (0 to 3) selects DF = 2^(LOG2_DF_MIN + LOG2_DF_STEP*s). With the defaults, 00, 01, 10 and 11 select 256, 1024, 4096 and 16384.
- R2: A rising edge on `mclk_in` while idle produces `conv_start_o` high for one cycle and `busy_o` high, both in the cycle after the clock edge that samples the rising edge. Rising edges on `mclk_in` while busy start nothing.
- R3: `busy_o` falls in the cycle after a clock edge that samples `conv_done_in` high while busy. `conv_done_in` while idle has no effect on any output.
- R4: `drl_o` rises together with `busy_o` when a boundary conversion starts. It falls together with `busy_o` when that conversion completes, and `load_o` is high for exactly that one cycle.
- R5: After reset, `busy_o`, `load_o`, `conv_start_o` and `filt_clr_o` are low and `drl_o` is high. The first `load_o` accompanies completion of the DF-th conversion.
- R6: A sync rising edge while the phase counter is zero and the strap equals the latched selection produces no `filt_clr_o` and leaves the update timing unchanged.
- R7: Any other sync rising edge zeroes the phase counter and pulses `filt_clr_o` for one cycle, in the cycle after the clock edge at which the sync is applied. The next `load_o` then comes with the DF-th conversion that completes after it.
- R8: Strap changes take effect only at reset or at a sync edge. A sync edge whose strap differs from the latched selection counts as a realignment, even when the counter is zero.
- R9: A sync edge sampled while busy is held. It is applied, using the count after the current conversion, in the first idle cycle after that conversion completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mclk_in | input | 1 | Master-clock conversion request (rising edge starts) |
| conv_done_in | input | 1 | Conversion-complete flag from the converter core |
| df_sel_in | input | 2 | Down-sampling factor strap |
| sync_in | input | 1 | Phase synchronization request (rising edge) |
| conv_start_o | output | 1 | One-cycle start pulse to the converter core |
| busy_o | output | 1 | High while a conversion is in progress |
| drl_o | output | 1 | Data-ready-low; falls when a new filtered word is loaded |
| load_o | output | 1 | One-cycle load enable for the filtered output register |
| filt_clr_o | output | 1 | One-cycle clear of the filter accumulator |

## Verification
The bench builds the block with LOG2_DF_MIN = 2 and LOG2_DF_STEP = 1, which gives factors of 4, 8, 16 and 32. Every strap setting, repeated wrap-arounds, re-phasing after a spurious extra conversion, and syncs that land during a busy conversion all fit in a few thousand cycles. The counter and comparator structure is the same one that the defaults size for 16384, only narrower.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  typedef enum logic [1:0] {
    SEL_X1  = 2'b00,
    SEL_X4  = 2'b01,
    SEL_X16 = 2'b10,
    SEL_X64 = 2'b11
  } df_sel_t;

  // Last count value (DF - 1) for a strap value.
  function automatic logic [31:0] df_last(input logic [1:0] sel,
                                          input int lmin,
                                          input int lstep);
    int sh;
    sh = lmin + lstep * int'(sel);
    return (32'd1 << sh) - 32'd1;
  endfunction

endpackage

// File: rtl/dpc_edge.sv
module dpc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise
);
  logic q;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end

  assign rise = d & ~q;
endmodule

// File: rtl/dpc_phase.sv
module dpc_phase #(
  parameter int LOG2_DF_MIN  = 8,
  parameter int LOG2_DF_STEP = 2,
  localparam int CW = LOG2_DF_MIN + 3 * LOG2_DF_STEP
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] df_sel,
  input  logic       sync_rise,
  input  logic       idle,
  input  logic       done_acc,
  output logic       boundary,
  output logic       filt_clr
);
  logic [CW-1:0] cnt_q, last_q, cnt_eff, last_eff, last_pin;
  logic [1:0]    sel_q;
  logic          pend_q, clr_q;
  logic          apply, aligned, realign;

  assign last_pin = CW'(dpc_pkg::df_last(df_sel, LOG2_DF_MIN, LOG2_DF_STEP));

  assign apply    = idle & (pend_q | sync_rise);
  assign aligned  = (cnt_q == '0) && (df_sel == sel_q);
  assign realign  = apply & ~aligned;
  assign cnt_eff  = realign ? '0 : cnt_q;
  assign last_eff = apply ? last_pin : last_q;
  assign boundary = (cnt_eff == last_eff);
  assign filt_clr = clr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= last_pin;
      sel_q  <= df_sel;
      pend_q <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q | sync_rise) & ~apply;
      clr_q  <= realign;
      if (apply) begin
        cnt_q  <= cnt_eff;
        sel_q  <= df_sel;
        last_q <= last_pin;
      end else if (done_acc) begin
        cnt_q <= (cnt_q == last_q) ? '0 : cnt_q + 1'b1;
      end
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_q); // R4
  AST_CLR_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |-> (cnt_q == '0)); // R7
  AST_PEND_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> !$past(idle)); // R9
endmodule

// File: rtl/dpc_seq.sv
module dpc_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic mclk_rise,
  input  logic conv_done,
  input  logic boundary,
  output logic busy,
  output logic conv_start,
  output logic drl,
  output logic load,
  output logic idle,
  output logic done_acc
);
  logic busy_q, start_q, drl_q, load_q, bnd_q;
  logic start;

  assign start      = mclk_rise & ~busy_q;
  assign done_acc   = busy_q & conv_done;
  assign idle       = ~busy_q;
  assign busy       = busy_q;
  assign conv_start = start_q;
  assign drl        = drl_q;
  assign load       = load_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      drl_q   <= 1'b1;
      load_q  <= 1'b0;
      bnd_q   <= 1'b0;
    end else begin
      start_q <= start;
      load_q  <= done_acc & bnd_q;
      if (start) begin
        busy_q <= 1'b1;
        bnd_q  <= boundary;
        if (boundary) drl_q <= 1'b1;
      end else if (done_acc) begin
        busy_q <= 1'b0;
        if (bnd_q) drl_q <= 1'b0;
      end
    end
  end

  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> start_q); // R2
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && mclk_rise) |=> !start_q); // R2
  AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && conv_done && !mclk_rise) |=> (!busy_q && !load_q)); // R3
  AST_LOAD_WITH_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |-> ($fell(busy_q) && $fell(drl_q))); // R4
  AST_DRL_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drl_q) |-> $rose(busy_q)); // R4
endmodule

// File: rtl/decim_phase_ctrl.sv
module decim_phase_ctrl #(
  parameter int LOG2_DF_MIN  = 8,
  parameter int LOG2_DF_STEP = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mclk_in,
  input  logic       conv_done_in,
  input  logic [1:0] df_sel_in,
  input  logic       sync_in,
  output logic       conv_start_o,
  output logic       busy_o,
  output logic       drl_o,
  output logic       load_o,
  output logic       filt_clr_o
);
  logic mclk_rise, sync_rise, boundary, idle, done_acc;

  dpc_edge u_mclk_edge (.clk(clk), .rst_n(rst_n), .d(mclk_in), .rise(mclk_rise));
  dpc_edge u_sync_edge (.clk(clk), .rst_n(rst_n), .d(sync_in), .rise(sync_rise));

  dpc_phase #(.LOG2_DF_MIN(LOG2_DF_MIN), .LOG2_DF_STEP(LOG2_DF_STEP)) u_phase (
    .clk(clk), .rst_n(rst_n), .df_sel(df_sel_in), .sync_rise(sync_rise),
    .idle(idle), .done_acc(done_acc), .boundary(boundary), .filt_clr(filt_clr_o)
  );

  dpc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .mclk_rise(mclk_rise), .conv_done(conv_done_in),
    .boundary(boundary), .busy(busy_o), .conv_start(conv_start_o), .drl(drl_o),
    .load(load_o), .idle(idle), .done_acc(done_acc)
  );

  AST_CLR_NOT_WITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    filt_clr_o |-> !load_o); // R7
endmodule

// File: tb/tb_decim_phase_ctrl.sv
module tb_decim_phase_ctrl;
  localparam int LMIN = 2;
  localparam int LSTEP = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mclk = 1'b0, conv_done = 1'b0, sync = 1'b0;
  logic [1:0] df_sel = 2'b00;
  logic conv_start, busy, drl, load, filt_clr;

  int tests = 0, fails = 0, loads = 0;
  int m_cnt = 0;
  logic [1:0] m_sel = 2'b00;
  bit finished = 0;

  always #2 clk = ~clk;

  decim_phase_ctrl #(.LOG2_DF_MIN(LMIN), .LOG2_DF_STEP(LSTEP)) dut (
    .clk(clk), .rst_n(rst_n), .mclk_in(mclk), .conv_done_in(conv_done),
    .df_sel_in(df_sel), .sync_in(sync), .conv_start_o(conv_start),
    .busy_o(busy), .drl_o(drl), .load_o(load), .filt_clr_o(filt_clr)
  );

  always @(negedge clk) if (rst_n && load) loads++;

  function automatic int m_last(input logic [1:0] s);
    return (1 << (LMIN + LSTEP * int'(s))) - 1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply_sync_model(input logic [1:0] s, output bit realign);
    realign = !(m_cnt == 0 && s == m_sel);
    if (realign) m_cnt = 0;
    m_sel = s;
  endtask

  task automatic do_conv(input bit extra, input bit sync_mid, input logic [1:0] ssel);
    bit bnd, re;
    bnd = (m_cnt == m_last(m_sel));
    @(negedge clk) mclk = 1'b1;
    @(negedge clk);
    chk("R2 busy after start", busy, 1);
    chk("R2 start pulse", conv_start, 1);
    if (bnd) chk("R4 drl high at boundary start", drl, 1);
    mclk = 1'b0;
    if (extra) begin
      @(negedge clk) mclk = 1'b1;
      @(negedge clk) mclk = 1'b0;
      chk("R2 edge while busy ignored", conv_start, 0);
      chk("R2 still busy", busy, 1);
    end
    if (sync_mid) begin
      df_sel = ssel;
      @(negedge clk) sync = 1'b1;
      @(negedge clk) sync = 1'b0;
      chk("R9 sync held while busy", filt_clr, 0);
    end
    repeat ($urandom_range(1, 4)) @(negedge clk);
    conv_done = 1'b1;
    @(negedge clk) conv_done = 1'b0;
    chk("R3 busy falls after done", busy, 0);
    chk("R4 load on boundary only", load, int'(bnd));
    if (bnd) chk("R4 drl falls with load", drl, 0);
    m_cnt = bnd ? 0 : m_cnt + 1;
    if (sync_mid) begin
      apply_sync_model(ssel, re);
      @(negedge clk);
      chk("R9 held sync applied after conversion", filt_clr, int'(re));
    end
    @(negedge clk);
  endtask

  task automatic do_sync(input logic [1:0] s);
    bit re;
    df_sel = s;
    @(negedge clk) sync = 1'b1;
    @(negedge clk) sync = 1'b0;
    apply_sync_model(s, re);
    if (re) chk("R7 realign clears filter", filt_clr, 1);
    else    chk("R6 aligned sync leaves filter", filt_clr, 0);
    @(negedge clk);
    chk("R7 clear is one cycle", filt_clr, 0);
  endtask

  initial begin
    int l0;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk("R5 reset busy", busy, 0);
    chk("R5 reset drl", drl, 1);
    chk("R5 reset load", load, 0);
    chk("R5 reset start", conv_start, 0);
    chk("R5 reset clear", filt_clr, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: first update at the DF-th conversion
    repeat (3) do_conv(0, 0, 2'b00);
    chk("R5 no load before DF-th", loads, 0);
    do_conv(0, 0, 2'b00);
    chk("R5 load at DF-th", loads, 1);

    // R1: each strap value gives its factor
    for (int s = 0; s < 4; s++) begin
      do_sync(2'(s));
      l0 = loads;
      repeat (2 * (m_last(2'(s)) + 1)) do_conv(0, 0, 2'b00);
      chk("R1 loads per 2*DF conversions", loads - l0, 2);
    end

    // R6: aligned sync (counter at zero, same strap)
    do_sync(2'b01);
    do_sync(2'b01);
    l0 = loads;
    repeat (8) do_conv(0, 0, 2'b00);
    chk("R6 timing unchanged after aligned sync", loads - l0, 1);

    // R7: spurious conversion, then re-phase
    do_conv(1, 0, 2'b00);
    do_sync(2'b01);
    l0 = loads;
    repeat (7) do_conv(0, 0, 2'b00);
    chk("R7 no load before DF after realign", loads - l0, 0);
    do_conv(0, 0, 2'b00);
    chk("R7 load at DF after realign", loads - l0, 1);

    // R8: strap change alone has no effect
    df_sel = 2'b00;
    l0 = loads;
    repeat (8) do_conv(0, 0, 2'b00);
    chk("R8 strap change ignored without sync", loads - l0, 1);
    chk("R8 counter at zero", m_cnt, 0);
    do_sync(2'b00);
    chk("R8 new strap counts as realign", int'(m_sel), 0);

    // R3: done while idle ignored
    @(negedge clk) conv_done = 1'b1;
    @(negedge clk) conv_done = 1'b0;
    chk("R3 idle done no busy", busy, 0);
    chk("R3 idle done no load", load, 0);
    @(negedge clk);

    // R9: syncs during conversions
    do_conv(0, 1, 2'b00);
    do_conv(0, 1, 2'b01);
    do_conv(1, 1, 2'b01);

    for (int i = 0; i < 300; i++) begin
      int r;
      logic [1:0] s;
      r = $urandom_range(0, 99);
      s = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : m_sel;
      if (r < 75)      do_conv(bit'($urandom_range(0, 1)), 0, 2'b00);
      else if (r < 88) do_sync(s);
      else             do_conv(0, 1, s);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule